// File: doc/BRIEF.md
# Shared Bus Ownership Arbiter for a Multi-Channel DMA Engine

This block decides, cycle by cycle, which master drives a shared memory bus: one of several DMA channels, a memory refresh requester, or the CPU. Every bus cycle lasts one clock. A DMA transfer always occupies the bus for a read cycle followed at once by the matching write cycle, and that pair is never split. After each write the arbiter decides whether the running channel keeps the bus or gives it up. That decision depends on the channel's transfer mode (cycle steal, burst or block), on its remaining transfer count and on its position inside the current block.

Each channel is held as a small set of counters: an active flag, a remaining transfer count, a remaining-in-block count and a mode. A start pulse loads new values into an idle channel. An abort pulse stops the channel and keeps its counters. A resume pulse restarts the channel from where it stopped, including partway through a block. A standby level clears every channel and cancels any bus cycle in progress. Refresh requests are pulses that the block latches until they are served. During a burst or block run, a pending refresh may take one cycle right after a write, and the run then continues.

Top module: `busown_arb`

## Requirements
- R1: A DMA read grant (gnt_dma=1, dma_wr=0) is followed in the next cycle by the write grant (gnt_dma=1, dma_wr=1) for the same dma_ch. Nothing else is granted between the two, and an abort arriving during the read does not cancel the write.
- R2: While a burst or block run holds the bus, a pending refresh is granted only in the cycle right after a write. The held channel then continues with its next read, and no other channel or the CPU takes over.
- R3: The CPU is never granted while a DMA run holds the bus. At a DMA release point, a requesting CPU is served ahead of the DMA channels. At all other free points, DMA channels come before the CPU.
- R4: A channel in cycle steal mode (cfg_mode=0) gives up the bus after every read/write pair.
- R5: When several active channels compete at a free point, the lowest-numbered one wins. A held run is never taken over by another channel.
- R6: A channel in burst mode (cfg_mode=1) keeps the bus until its remaining count reaches zero. Each write lowers ch_remain by one, and the channel goes inactive when the count reaches zero.
- R7: A channel in block mode (cfg_mode=2) gives up the bus after each block. The block counter ch_blkrem drops by one per write and reloads from the configured block size when the block ends. A block size of 0 or 1 means one transfer per block.
- R8: An abort pulse clears the channel's active flag on the next cycle and leaves ch_remain and ch_blkrem unchanged. A later resume pulse reactivates the channel, which continues from its kept count and kept block position. If both arrive together, the abort wins.
- R9: While standby is high, and during reset, no grant is given and all channel counters and active flags read zero.
- R10: A latched refresh request wins at every free point and at every release point. Each request produces exactly one refresh cycle, and requests arriving while one is already pending are merged.
- R11: At most one of gnt_dma, gnt_ref and gnt_cpu is high in any cycle. With no requests, the bus stays idle with no grant.
- R12: A start pulse to a channel that is active, or whose pair is completing in that cycle, is ignored. A resume pulse to a channel whose remaining count is zero has no effect. A start with a count of zero leaves the channel inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Synchronous clear of all state while high |
| ref_req | input | 1 | Refresh request pulse |
| cpu_req | input | 1 | CPU bus request level |
| ch_start | input | NCH | Per-channel start pulse (loads configuration) |
| ch_resume | input | NCH | Per-channel resume pulse |
| ch_abort | input | NCH | Per-channel abort pulse |
| cfg_mode | input | 2*NCH | Per-channel mode: 0 cycle steal, 1 burst, 2 block |
| cfg_count | input | CNT_W*NCH | Per-channel transfer count loaded on start |
| cfg_blk | input | BLK_W*NCH | Per-channel block size loaded on start |
| gnt_dma | output | 1 | DMA owns the bus this cycle |
| dma_wr | output | 1 | DMA cycle is the write half of the pair |
| dma_ch | output | CH_W | Channel owning the DMA cycle |
| gnt_ref | output | 1 | Refresh owns the bus this cycle |
| gnt_cpu | output | 1 | CPU owns the bus this cycle |
| ch_active | output | NCH | Per-channel active flag |
| ch_remain | output | CNT_W*NCH | Per-channel remaining transfer count |
| ch_blkrem | output | BLK_W*NCH | Per-channel remaining transfers in the current block |

## Verification
Each mode is first run on its own with the CPU requesting all the time. The longest unbroken stretch of DMA cycles then shows where the release points lie: two cycles for cycle steal, the whole count for burst, one block for block mode. A refresh pulse dropped into a burst shows that refresh lands only after a write and that the same run then continues. Two channels started in the same cycle expose the priority order. Aborts placed mid-burst and mid-block, each followed by a resume, show that position is kept. Starts sent to a busy channel, resumes sent to an empty one, and standby asserted mid-run check that ignored or clearing inputs act as required.

// File: rtl/busown_pkg.sv
package busown_pkg;

   typedef enum logic [1:0] {
      XM_STEAL = 2'd0,
      XM_BURST = 2'd1,
      XM_BLOCK = 2'd2
   } xfer_mode_e;

   typedef enum logic [2:0] {
      OWN_IDLE = 3'd0,
      OWN_RD   = 3'd1,
      OWN_WR   = 3'd2,
      OWN_REF  = 3'd3,
      OWN_CPU  = 3'd4
   } owner_e;

endpackage

// File: rtl/busown_prio.sv
module busown_prio #(
   parameter int N         = 4,
   parameter bit LOW_FIRST = 1'b1,
   localparam int W        = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0] req,
   output logic         hit,
   output logic [W-1:0] idx
);

   assign hit = |req;

   generate
      if (LOW_FIRST) begin : g_low
         always_comb begin
            idx = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req[i]) idx = W'(i);
            end
         end
      end else begin : g_high
         always_comb begin
            idx = '0;
            for (int i = 0; i < N; i++) begin
               if (req[i]) idx = W'(i);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/busown_chan.sv
module busown_chan
   import busown_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int BLK_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             standby,
   input  logic             start,
   input  logic             resume,
   input  logic             abort,
   input  logic [1:0]       mode_load,
   input  logic [CNT_W-1:0] cnt_load,
   input  logic [BLK_W-1:0] blk_load,
   input  logic             xfer_done,
   output logic             active,
   output logic [CNT_W-1:0] cnt,
   output logic [BLK_W-1:0] blk,
   output logic             elig,
   output logic             cont,
   output logic             last
);

   logic             act_q;
   logic [CNT_W-1:0] cnt_q;
   logic [BLK_W-1:0] blk_q;
   logic [BLK_W-1:0] bsz_q;
   xfer_mode_e       mode_q;
   xfer_mode_e       mode_dec;
   logic             blk_end;

   always_comb begin
      unique case (mode_load)
         2'd1:    mode_dec = XM_BURST;
         2'd2:    mode_dec = XM_BLOCK;
         default: mode_dec = XM_STEAL;
      endcase
   end

   assign last    = (cnt_q == CNT_W'(1));
   assign blk_end = (blk_q <= BLK_W'(1));
   assign elig    = act_q & ~abort;
   assign cont    = elig & ~last &
                    ((mode_q == XM_BURST) | ((mode_q == XM_BLOCK) & ~blk_end));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         cnt_q  <= '0;
         blk_q  <= '0;
         bsz_q  <= '0;
         mode_q <= XM_STEAL;
      end else if (standby) begin
         act_q  <= 1'b0;
         cnt_q  <= '0;
         blk_q  <= '0;
         bsz_q  <= '0;
         mode_q <= XM_STEAL;
      end else begin
         if (xfer_done) begin
            cnt_q <= cnt_q - CNT_W'(1);
            if (mode_q == XM_BLOCK) blk_q <= blk_end ? bsz_q : blk_q - BLK_W'(1);
            if (last) act_q <= 1'b0;
         end
         if (abort) begin
            act_q <= 1'b0;
         end else if (!xfer_done && !act_q) begin
            if (start) begin
               cnt_q  <= cnt_load;
               bsz_q  <= blk_load;
               blk_q  <= blk_load;
               mode_q <= mode_dec;
               act_q  <= (cnt_load != '0);
            end else if (resume && (cnt_q != '0)) begin
               act_q <= 1'b1;
            end
         end
      end
   end

   assign active = act_q;
   assign cnt    = cnt_q;
   assign blk    = blk_q;

endmodule

// File: rtl/busown_seq.sv
module busown_seq
   import busown_pkg::*;
#(
   parameter int NCH       = 4,
   parameter bit LOW_FIRST = 1'b1,
   localparam int CH_W     = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            standby,
   input  logic            ref_req,
   input  logic            cpu_req,
   input  logic [NCH-1:0]  elig,
   input  logic [NCH-1:0]  cont,
   input  logic [NCH-1:0]  last,
   output owner_e          state,
   output logic [CH_W-1:0] cur,
   output logic [NCH-1:0]  done
);

   owner_e          state_q, nxt;
   logic [CH_W-1:0] cur_q, nch;
   logic            held_q, nheld;
   logic            pend_q, pend;
   logic [NCH-1:0]  cur_oh;
   logic [NCH-1:0]  elig_rel;
   logic            hit;
   logic [CH_W-1:0] idx;

   assign cur_oh   = NCH'(1) << cur_q;
   assign elig_rel = (state_q == OWN_WR) ? (elig & ~(last & cur_oh)) : elig;
   assign pend     = pend_q | ref_req;

   busown_prio #(.N(NCH), .LOW_FIRST(LOW_FIRST)) u_pick (
      .req (elig_rel),
      .hit (hit),
      .idx (idx)
   );

   always_comb begin
      nxt   = state_q;
      nch   = cur_q;
      nheld = 1'b0;
      unique case (state_q)
         OWN_RD: nxt = OWN_WR;
         OWN_WR: begin
            if (cont[cur_q]) begin
               if (pend) begin
                  nxt   = OWN_REF;
                  nheld = 1'b1;
               end else begin
                  nxt = OWN_RD;
               end
            end else if (pend) begin
               nxt = OWN_REF;
            end else if (cpu_req) begin
               nxt = OWN_CPU;
            end else if (hit) begin
               nxt = OWN_RD;
               nch = idx;
            end else begin
               nxt = OWN_IDLE;
            end
         end
         default: begin
            if ((state_q == OWN_REF) && held_q && elig[cur_q]) begin
               nxt = OWN_RD;
            end else if (pend) begin
               nxt = OWN_REF;
            end else if (hit) begin
               nxt = OWN_RD;
               nch = idx;
            end else if (cpu_req) begin
               nxt = OWN_CPU;
            end else begin
               nxt = OWN_IDLE;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= OWN_IDLE;
         cur_q   <= '0;
         held_q  <= 1'b0;
         pend_q  <= 1'b0;
      end else if (standby) begin
         state_q <= OWN_IDLE;
         cur_q   <= '0;
         held_q  <= 1'b0;
         pend_q  <= 1'b0;
      end else begin
         state_q <= nxt;
         cur_q   <= nch;
         held_q  <= nheld;
         pend_q  <= pend & (nxt != OWN_REF);
      end
   end

   assign state = state_q;
   assign cur   = cur_q;
   assign done  = (state_q == OWN_WR) ? cur_oh : '0;

endmodule

// File: rtl/busown_arb.sv
module busown_arb
   import busown_pkg::*;
#(
   parameter int NCH       = 4,
   parameter int CNT_W     = 16,
   parameter int BLK_W     = 8,
   parameter bit LOW_FIRST = 1'b1,
   localparam int CH_W     = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 standby,
   input  logic                 ref_req,
   input  logic                 cpu_req,
   input  logic [NCH-1:0]       ch_start,
   input  logic [NCH-1:0]       ch_resume,
   input  logic [NCH-1:0]       ch_abort,
   input  logic [2*NCH-1:0]     cfg_mode,
   input  logic [CNT_W*NCH-1:0] cfg_count,
   input  logic [BLK_W*NCH-1:0] cfg_blk,
   output logic                 gnt_dma,
   output logic                 dma_wr,
   output logic [CH_W-1:0]      dma_ch,
   output logic                 gnt_ref,
   output logic                 gnt_cpu,
   output logic [NCH-1:0]       ch_active,
   output logic [CNT_W*NCH-1:0] ch_remain,
   output logic [BLK_W*NCH-1:0] ch_blkrem
);

   generate
      if (NCH < 2) begin : g_bad_nch
         $error("busown_arb: NCH must be at least 2");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("busown_arb: CNT_W must be at least 2");
      end
      if (BLK_W < 1) begin : g_bad_blk
         $error("busown_arb: BLK_W must be at least 1");
      end
   endgenerate

   owner_e          state;
   logic [CH_W-1:0] cur;
   logic [NCH-1:0]  done, elig, cont, last;

   busown_seq #(.NCH(NCH), .LOW_FIRST(LOW_FIRST)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .standby (standby),
      .ref_req (ref_req),
      .cpu_req (cpu_req),
      .elig    (elig),
      .cont    (cont),
      .last    (last),
      .state   (state),
      .cur     (cur),
      .done    (done)
   );

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_ch
         busown_chan #(.CNT_W(CNT_W), .BLK_W(BLK_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .standby   (standby),
            .start     (ch_start[g]),
            .resume    (ch_resume[g]),
            .abort     (ch_abort[g]),
            .mode_load (cfg_mode[2*g +: 2]),
            .cnt_load  (cfg_count[CNT_W*g +: CNT_W]),
            .blk_load  (cfg_blk[BLK_W*g +: BLK_W]),
            .xfer_done (done[g]),
            .active    (ch_active[g]),
            .cnt       (ch_remain[CNT_W*g +: CNT_W]),
            .blk       (ch_blkrem[BLK_W*g +: BLK_W]),
            .elig      (elig[g]),
            .cont      (cont[g]),
            .last      (last[g])
         );
      end
   endgenerate

   assign gnt_dma = (state == OWN_RD) || (state == OWN_WR);
   assign dma_wr  = (state == OWN_WR);
   assign dma_ch  = cur;
   assign gnt_ref = (state == OWN_REF);
   assign gnt_cpu = (state == OWN_CPU);

endmodule

// File: rtl/busown_arb_chk.sv
module busown_arb_chk #(
   parameter int NCH  = 4,
   parameter int CH_W = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            standby,
   input logic            ref_req,
   input logic [NCH-1:0]  ch_abort,
   input logic            gnt_dma,
   input logic            dma_wr,
   input logic [CH_W-1:0] dma_ch,
   input logic            gnt_ref,
   input logic            gnt_cpu,
   input logic [NCH-1:0]  ch_active
);

   // R1
   rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n || standby)
      (gnt_dma && !dma_wr) |=> (gnt_dma && dma_wr && $stable(dma_ch)));

   // R2
   ref_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n || standby)
      (gnt_dma && !dma_wr) |=> !gnt_ref);

   // R10
   ref_single_chk: assert property (@(posedge clk) disable iff (!rst_n || standby)
      (gnt_ref && !ref_req) |=> !gnt_ref);

   // R11
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gnt_dma, gnt_ref, gnt_cpu}));

   // R9
   standby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      standby |=> (!gnt_dma && !gnt_ref && !gnt_cpu && (ch_active == '0)));

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_abort
         // R8
         abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_abort[g] |=> !ch_active[g]);
      end
   endgenerate

endmodule

bind busown_arb busown_arb_chk #(.NCH(NCH), .CH_W(CH_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .standby   (standby),
   .ref_req   (ref_req),
   .ch_abort  (ch_abort),
   .gnt_dma   (gnt_dma),
   .dma_wr    (dma_wr),
   .dma_ch    (dma_ch),
   .gnt_ref   (gnt_ref),
   .gnt_cpu   (gnt_cpu),
   .ch_active (ch_active)
);

// File: tb/busown_arb_bench.sv
module busown_arb_bench;

   localparam int NCH   = 4;
   localparam int CNT_W = 16;
   localparam int BLK_W = 8;
   localparam int CH_W  = 2;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 standby = 1'b0;
   logic                 ref_req = 1'b0;
   logic                 cpu_req = 1'b0;
   logic [NCH-1:0]       ch_start = '0;
   logic [NCH-1:0]       ch_resume = '0;
   logic [NCH-1:0]       ch_abort = '0;
   logic [2*NCH-1:0]     cfg_mode = '0;
   logic [CNT_W*NCH-1:0] cfg_count = '0;
   logic [BLK_W*NCH-1:0] cfg_blk = '0;
   logic                 gnt_dma, dma_wr, gnt_ref, gnt_cpu;
   logic [CH_W-1:0]      dma_ch;
   logic [NCH-1:0]       ch_active;
   logic [CNT_W*NCH-1:0] ch_remain;
   logic [BLK_W*NCH-1:0] ch_blkrem;

   always #5 clk = ~clk;

   busown_arb #(.NCH(NCH), .CNT_W(CNT_W), .BLK_W(BLK_W)) u_busown_arb (
      .clk, .rst_n, .standby, .ref_req, .cpu_req, .ch_start, .ch_resume, .ch_abort,
      .cfg_mode, .cfg_count, .cfg_blk, .gnt_dma, .dma_wr, .dma_ch, .gnt_ref, .gnt_cpu,
      .ch_active, .ch_remain, .ch_blkrem
   );

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Reference model: 0 idle, 1 read, 2 write, 3 refresh, 4 cpu
   int m_state, m_ch, m_held, m_pend;
   int m_act[NCH], m_cnt[NCH], m_blk[NCH], m_bsz[NCH], m_mode[NCH];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n || standby) begin
         m_state = 0; m_ch = 0; m_held = 0; m_pend = 0;
         for (int i = 0; i < NCH; i++) begin
            m_act[i] = 0; m_cnt[i] = 0; m_blk[i] = 0; m_bsz[i] = 0; m_mode[i] = 0;
         end
      end else begin
         int el[NCH], ls[NCH], be[NCH], co[NCH];
         int pend, pick, nst, nch, nheld;
         pend = m_pend | ref_req;
         pick = -1;
         for (int i = 0; i < NCH; i++) begin
            el[i] = m_act[i] && !ch_abort[i];
            ls[i] = (m_cnt[i] == 1);
            be[i] = (m_blk[i] <= 1);
            co[i] = el[i] && !ls[i] && (m_mode[i] == 1 || (m_mode[i] == 2 && !be[i]));
         end
         for (int i = 0; i < NCH; i++)
            if (pick < 0 && el[i] && !(m_state == 2 && i == m_ch && ls[i])) pick = i;
         nch = m_ch; nheld = 0;
         if (m_state == 1) nst = 2;
         else if (m_state == 2) begin
            if (co[m_ch]) begin
               if (pend) begin nst = 3; nheld = 1; end else nst = 1;
            end else if (pend) nst = 3;
            else if (cpu_req) nst = 4;
            else if (pick >= 0) begin nst = 1; nch = pick; end
            else nst = 0;
         end else begin
            if (m_state == 3 && m_held && el[m_ch]) nst = 1;
            else if (pend) nst = 3;
            else if (pick >= 0) begin nst = 1; nch = pick; end
            else if (cpu_req) nst = 4;
            else nst = 0;
         end
         for (int i = 0; i < NCH; i++) begin
            int d, oa;
            d = (m_state == 2 && m_ch == i);
            oa = m_act[i];
            if (d) begin
               m_cnt[i] = (m_cnt[i] - 1) & 16'hFFFF;
               if (m_mode[i] == 2) m_blk[i] = be[i] ? m_bsz[i] : m_blk[i] - 1;
               if (ls[i]) m_act[i] = 0;
            end
            if (ch_abort[i]) m_act[i] = 0;
            else if (!d && !oa) begin
               if (ch_start[i]) begin
                  m_cnt[i] = cfg_count[CNT_W*i +: CNT_W];
                  m_bsz[i] = cfg_blk[BLK_W*i +: BLK_W];
                  m_blk[i] = m_bsz[i];
                  m_mode[i] = (cfg_mode[2*i +: 2] == 2'd3) ? 0 : cfg_mode[2*i +: 2];
                  m_act[i] = (m_cnt[i] != 0);
               end else if (ch_resume[i] && m_cnt[i] != 0) m_act[i] = 1;
            end
         end
         m_pend = pend && (nst != 3);
         m_state = nst; m_ch = nch; m_held = nheld;
      end
   end

   // Per-cycle comparison and observers
   int run = 0, max_run = 0, refs = 0, ref_after_rd = 0, first_ch = -1;
   bit prev_rd = 0;

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(gnt_dma == (m_state == 1 || m_state == 2), "R1 dma grant", gnt_dma, m_state);
         chk(dma_wr == (m_state == 2), "R1 write phase", dma_wr, m_state);
         chk(gnt_ref == (m_state == 3), "R10 refresh grant", gnt_ref, m_state);
         chk(gnt_cpu == (m_state == 4), "R3 cpu grant", gnt_cpu, m_state);
         chk($countones({gnt_dma, gnt_ref, gnt_cpu}) <= 1, "R11 single grant",
             $countones({gnt_dma, gnt_ref, gnt_cpu}), 1);
         if (gnt_dma) chk(dma_ch == m_ch, "R5 owning channel", dma_ch, m_ch);
         for (int i = 0; i < NCH; i++) begin
            chk(ch_active[i] == m_act[i], "R8 active flag", ch_active[i], m_act[i]);
            chk(ch_remain[CNT_W*i +: CNT_W] == m_cnt[i], "R6 remaining count",
                ch_remain[CNT_W*i +: CNT_W], m_cnt[i]);
            chk(ch_blkrem[BLK_W*i +: BLK_W] == m_blk[i], "R7 block position",
                ch_blkrem[BLK_W*i +: BLK_W], m_blk[i]);
         end
         if (gnt_dma) run++; else run = 0;
         if (run > max_run) max_run = run;
         if (gnt_ref) refs++;
         if (gnt_ref && prev_rd) ref_after_rd++;
         if (gnt_dma && first_ch < 0) first_ch = dma_ch;
         prev_rd = gnt_dma && !dma_wr;
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic obs_clear();
      max_run = 0; refs = 0; ref_after_rd = 0; first_ch = -1;
   endtask

   task automatic start_ch(input int c, input int mode, input int cnt, input int bsz);
      cfg_mode[2*c +: 2] = 2'(mode);
      cfg_count[CNT_W*c +: CNT_W] = CNT_W'(cnt);
      cfg_blk[BLK_W*c +: BLK_W] = BLK_W'(bsz);
      ch_start[c] = 1'b1;
      cyc(1);
      ch_start[c] = 1'b0;
   endtask

   function automatic int rem(input int c);
      return int'(ch_remain[CNT_W*c +: CNT_W]);
   endfunction

   task automatic finish_run();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      finish_run();
   end

   initial begin
      int kept;
      cyc(3);
      // R9 reset state
      chk({gnt_dma, gnt_ref, gnt_cpu} == 3'b000, "R9 reset grants", {gnt_dma, gnt_ref, gnt_cpu}, 0);
      chk(ch_active == '0 && ch_remain == '0, "R9 reset counters", ch_active, 0);
      rst_n = 1'b1;
      cyc(4);
      // R11 idle bus without requests
      chk({gnt_dma, gnt_ref, gnt_cpu} == 3'b000, "R11 idle no grant", {gnt_dma, gnt_ref, gnt_cpu}, 0);

      // R4 cycle steal with CPU waiting
      obs_clear(); cpu_req = 1'b1;
      start_ch(1, 0, 3, 0);
      cyc(14);
      chk(max_run == 2, "R4 steal release per pair", max_run, 2);
      chk(rem(1) == 0, "R4 steal count done", rem(1), 0);

      // R6 burst holds until count ends, CPU waits (R3)
      obs_clear();
      start_ch(2, 1, 4, 0);
      cyc(16);
      chk(max_run == 8, "R6 burst run length", max_run, 8);
      chk(!ch_active[2], "R3 cpu served after burst", ch_active[2], 0);

      // R7 block releases per block
      obs_clear();
      start_ch(0, 2, 6, 2);
      cyc(20);
      chk(max_run == 4, "R7 block run length", max_run, 4);
      chk(rem(0) == 0, "R7 block count done", rem(0), 0);
      cpu_req = 1'b0;
      cyc(3);

      // R2 refresh during burst only after a write
      obs_clear();
      start_ch(2, 1, 5, 0);
      cyc(3);
      ref_req = 1'b1; cyc(1); ref_req = 1'b0;
      cyc(14);
      chk(ref_after_rd == 0, "R2 refresh after read", ref_after_rd, 0);
      chk(refs == 1, "R10 one refresh per request", refs, 1);
      chk(rem(2) == 0, "R2 burst resumed to end", rem(2), 0);

      // R10 refresh at idle, merged back-to-back request
      obs_clear();
      ref_req = 1'b1; cyc(1); ref_req = 1'b0;
      cyc(4);
      chk(refs == 1, "R10 single refresh cycle", refs, 1);

      // R5 lowest channel wins
      obs_clear();
      cfg_mode[2*1 +: 2] = 2'd0; cfg_count[CNT_W*1 +: CNT_W] = 16'd2;
      cfg_mode[2*3 +: 2] = 2'd0; cfg_count[CNT_W*3 +: CNT_W] = 16'd2;
      ch_start = 4'b1010; cyc(1); ch_start = '0;
      cyc(12);
      chk(first_ch == 1, "R5 lowest channel first", first_ch, 1);
      chk(rem(3) == 0, "R5 second channel served", rem(3), 0);

      // R8 abort mid burst, keep position, resume
      start_ch(0, 1, 10, 0);
      cyc(5);
      ch_abort[0] = 1'b1; cyc(1); ch_abort[0] = 1'b0;
      cyc(3);
      kept = rem(0);
      chk(!ch_active[0], "R8 abort stops channel", ch_active[0], 0);
      chk(kept > 0 && kept < 10, "R8 position kept", kept, 5);
      cyc(4);
      chk(rem(0) == kept, "R8 count held while stopped", rem(0), kept);
      ch_resume[0] = 1'b1; cyc(1); ch_resume[0] = 1'b0;
      cyc(25);
      chk(rem(0) == 0, "R8 resume completes", rem(0), 0);

      // R8 abort mid block, resume from inside the block
      start_ch(1, 2, 8, 4);
      cyc(4);
      ch_abort[1] = 1'b1; cyc(1); ch_abort[1] = 1'b0;
      cyc(4);
      ch_resume[1] = 1'b1; cyc(1); ch_resume[1] = 1'b0;
      cyc(30);
      chk(rem(1) == 0, "R8 block resume completes", rem(1), 0);

      // R12 start while active ignored; resume with zero count ignored
      start_ch(2, 1, 5, 0);
      start_ch(2, 1, 9, 0);
      chk(rem(2) <= 5, "R12 start while active ignored", rem(2), 5);
      cyc(15);
      ch_resume[2] = 1'b1; cyc(1); ch_resume[2] = 1'b0;
      cyc(2);
      chk(!ch_active[2], "R12 resume with zero count", ch_active[2], 0);
      start_ch(3, 1, 0, 0);
      cyc(2);
      chk(!ch_active[3], "R12 zero count start", ch_active[3], 0);

      // R9 standby cancels a run
      start_ch(3, 1, 20, 0);
      cyc(4);
      standby = 1'b1; cyc(2);
      chk({gnt_dma, gnt_ref, gnt_cpu} == 3'b000, "R9 standby grants", {gnt_dma, gnt_ref, gnt_cpu}, 0);
      chk(rem(3) == 0 && ch_active == '0, "R9 standby clears", rem(3), 0);
      standby = 1'b0;
      cyc(3);

      finish_run();
   end

endmodule